// File: doc/BRIEF.md
# Single-Step Shift Unit with Condition Flags

This block does the one-position shifts and rotates of a small 8-bit processor datapath. An operand, a carry-in and a 3-bit operation code go in. The shifted value comes out combinationally in the same cycle. The four condition flags (negative, zero, overflow, carry) that the operation produces are captured in a register on the next rising clock edge, when the flag-write input is high.

Right shifts come in three forms: arithmetic, logical and rotate-through-carry. The left side has one shift code, which serves for both arithmetic and logical use, plus a rotate-through-carry. A signed-halving operation first adds the operand's sign bit in a 9-bit intermediate and then shifts right arithmetically. The quotient therefore truncates toward zero, where a plain arithmetic shift rounds toward negative infinity.

Overflow is defined as a change of the sign bit caused by a left move. No right move can overflow.

Top module: `shift_flag_unit`

## Requirements
- R1: Opcode 000 (arithmetic right) returns the operand moved right by one, with bit 7 kept and copied into bit 6. For example 0xFF gives 0xFF.
- R2: Opcode 001 (logical right) returns the operand moved right by one, with zero entering bit 7.
- R3: Opcode 010 (left shift) returns the operand moved left by one, with zero entering bit 0. The old bit 7 goes to C.
- R4: On opcodes 010 and 011, V is set exactly when bit 7 of the result differs from bit 7 of the operand. On every right-moving opcode (000, 001, 100, 101), V is cleared.
- R5: Opcode 011 (rotate left through carry) puts carryIn into bit 0 and the old bit 7 into C. Opcode 100 (rotate right through carry) puts carryIn into bit 7 and the old bit 0 into C.
- R6: Opcode 101 (signed halving) adds the operand's sign bit in 9 bits and then shifts right arithmetically. The result is the operand divided by two, truncated toward zero: 0xFF→0x00, 0xFD→0xFF, 0x80→0xC0, 0x7F→0x3F.
- R7: For every right-moving opcode, C takes the bit shifted out of bit 0. For signed halving, that bit is taken from the pre-added value.
- R8: For every valid opcode, Z is set exactly when the 8-bit result is zero, and N equals bit 7 of the result.
- R9: The flags change only on a rising edge where flagWrite is high. Otherwise they hold.
- R10: Opcodes 110 and 111 are reserved. The result equals the operand, and the flags do not change even when flagWrite is high.
- R11: A synchronous reset clears all four flags, and it takes priority over flagWrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| operand | input | 8 | Value to shift |
| carryIn | input | 1 | Carry fed into rotate operations |
| opcode | input | 3 | Operation select |
| flagWrite | input | 1 | Capture flags on this edge |
| result | output | 8 | Combinational shifted value |
| flagN | output | 1 | Registered negative flag |
| flagZ | output | 1 | Registered zero flag |
| flagV | output | 1 | Registered overflow flag |
| flagC | output | 1 | Registered carry flag |

## Verification
Random operands, carry-ins, opcodes and flag-write values cover the general case. Each result is compared with a model built on integer division and plain bit slicing.

Operands 0x40 and 0xC0 on the left shift separate a real sign change from a bit 7 that stays set. Operands 0xFF, 0xFD, 0x80 and 0x7F separate truncation toward zero from flooring, and also catch a wraparound in the pre-add. The same 0xFF on the arithmetic right shift confirms that plain shifting still floors.

Reserved codes sent with flag-write high, and a reset asserted together with flag-write, check the hold and clear paths at the flag outputs.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;

  typedef enum logic [2:0] {
    OP_SRA  = 3'd0,
    OP_SRL  = 3'd1,
    OP_SHL  = 3'd2,
    OP_RLC  = 3'd3,
    OP_RRC  = 3'd4,
    OP_HALF = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } shiftOp_e;

  typedef enum logic [1:0] {
    FILL_ZERO  = 2'd0,
    FILL_SIGN  = 2'd1,
    FILL_CARRY = 2'd2
  } fillSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic     goLeft;
    fillSrc_e fill;
    logic     preAdd;
    logic     leftOverflow;
    logic     opValid;
  } shiftStrobe_t;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flagSet_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_unit_pkg::*;
(
  input  logic [2:0]   opcode,
  output shiftStrobe_t strobe
);

  shiftOp_e op;
  assign op = shiftOp_e'(opcode);

  always_comb begin
    strobe = '{goLeft: 1'b0, fill: FILL_ZERO, preAdd: 1'b0,
               leftOverflow: 1'b0, opValid: 1'b1};
    case (op)
      OP_SRA:  strobe.fill = FILL_SIGN;
      OP_SRL:  strobe.fill = FILL_ZERO;
      OP_SHL: begin
        strobe.goLeft       = 1'b1;
        strobe.leftOverflow = 1'b1;
      end
      OP_RLC: begin
        strobe.goLeft       = 1'b1;
        strobe.fill         = FILL_CARRY;
        strobe.leftOverflow = 1'b1;
      end
      OP_RRC:  strobe.fill = FILL_CARRY;
      OP_HALF: begin
        strobe.fill   = FILL_SIGN;
        strobe.preAdd = 1'b1;
      end
      default: strobe.opValid = 1'b0;
    endcase
  end

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_unit_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] operand,
  input  logic             carryIn,
  input  shiftStrobe_t     strobe,
  output logic [WIDTH-1:0] result,
  output flagSet_t         nextFlags
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0]   widened;
  logic [WIDTH-1:0] src;
  logic             srcSign;
  logic             fillBit;
  logic             outBit;

  // sign-extended operand plus optional sign pre-add, one bit wider
  assign widened = {operand[MSB], operand}
                 + {{WIDTH{1'b0}}, operand[MSB] & strobe.preAdd};
  assign src     = widened[MSB:0];
  assign srcSign = widened[WIDTH];

  always_comb begin
    case (strobe.fill)
      FILL_SIGN:  fillBit = srcSign;
      FILL_CARRY: fillBit = carryIn;
      default:    fillBit = 1'b0;
    endcase
  end

  always_comb begin
    if (!strobe.opValid) begin
      result = operand;
      outBit = 1'b0;
    end else if (strobe.goLeft) begin
      result = {src[MSB-1:0], fillBit};
      outBit = src[MSB];
    end else begin
      result = {fillBit, src[MSB:1]};
      outBit = src[0];
    end
  end

  always_comb begin
    nextFlags.n = result[MSB];
    nextFlags.z = ~|result;
    nextFlags.v = strobe.leftOverflow & (result[MSB] ^ operand[MSB]);
    nextFlags.c = outBit;
  end

endmodule

// File: rtl/flag_reg.sv
module flag_reg
  import shift_unit_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  flagSet_t nextFlags,
  output flagSet_t flags
);

  always_ff @(posedge clk) begin
    if (rst)       flags <= '0;
    else if (load) flags <= nextFlags;
  end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit
  import shift_unit_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] operand,
  input  logic             carryIn,
  input  logic [2:0]       opcode,
  input  logic             flagWrite,
  output logic [WIDTH-1:0] result,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagV,
  output logic             flagC
);

  shiftStrobe_t strobe;
  flagSet_t     nextFlags;
  flagSet_t     flags;

  shift_ctrl ctrl (
    .opcode (opcode),
    .strobe (strobe)
  );

  shift_datapath #(.WIDTH(WIDTH)) dp (
    .operand   (operand),
    .carryIn   (carryIn),
    .strobe    (strobe),
    .result    (result),
    .nextFlags (nextFlags)
  );

  flag_reg flagStore (
    .clk       (clk),
    .rst       (rst),
    .load      (flagWrite & strobe.opValid),
    .nextFlags (nextFlags),
    .flags     (flags)
  );

  assign flagN = flags.n;
  assign flagZ = flags.z;
  assign flagV = flags.v;
  assign flagC = flags.c;

endmodule

// File: rtl/shift_unit_checker.sv
module shift_unit_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] operand,
  input logic             carryIn,
  input logic [2:0]       opcode,
  input logic             flagWrite,
  input logic [WIDTH-1:0] result,
  input logic             flagN,
  input logic             flagZ,
  input logic             flagV,
  input logic             flagC
);

  localparam int MSB = WIDTH - 1;

  logic pastRst;
  logic reserved;
  logic rightOp;

  assign reserved = (opcode[2:1] == 2'b11);
  assign rightOp  = (opcode == 3'd0) || (opcode == 3'd1)
                 || (opcode == 3'd4) || (opcode == 3'd5);

  always_ff @(posedge clk) pastRst <= rst;

  // R11
  always @(negedge clk)
    if (pastRst === 1'b1)
      reset_clear_chk: assert ({flagN, flagZ, flagV, flagC} == 4'b0);

  // R1
  sra_keep_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == 3'd0) |-> (result[MSB] == operand[MSB]
                          && result[MSB-1:0] == operand[MSB:1]));

  // R3
  shl_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (opcode == 3'd2) |-> (result[0] == 1'b0));

  // R4
  no_overflow_right_chk: assert property (@(posedge clk) disable iff (rst)
    (flagWrite && rightOp) |=> !flagV);

  // R8
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (flagWrite && !reserved) |=> (flagZ == ($past(result) == '0)));

  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flagWrite |=> $stable({flagN, flagZ, flagV, flagC}));

  // R10
  reserved_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    reserved |-> (result == operand));

  // R10
  reserved_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    reserved |=> $stable({flagN, flagZ, flagV, flagC}));

  logic unusedCarry;
  assign unusedCarry = carryIn;

endmodule

bind shift_flag_unit shift_unit_checker #(.WIDTH(WIDTH)) chk (
  .clk       (clk),
  .rst       (rst),
  .operand   (operand),
  .carryIn   (carryIn),
  .opcode    (opcode),
  .flagWrite (flagWrite),
  .result    (result),
  .flagN     (flagN),
  .flagZ     (flagZ),
  .flagV     (flagV),
  .flagC     (flagC)
);

// File: tb/shift_flag_unit_test.sv
module shift_flag_unit_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] operand;
  logic       carryIn;
  logic [2:0] opcode;
  logic       flagWrite;
  logic [7:0] result;
  logic       flagN, flagZ, flagV, flagC;

  int  checkCount = 0;
  int  failCount  = 0;
  bit  done       = 1'b0;
  logic [3:0] expFlags;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_flag_unit uut (
    .clk(clk), .rst(rst), .operand(operand), .carryIn(carryIn),
    .opcode(opcode), .flagWrite(flagWrite), .result(result),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );

  // {valid, result[7:0], n, z, v, c}
  function automatic logic [12:0] model(input logic [2:0] op,
                                        input logic [7:0] a,
                                        input logic cin);
    logic signed [7:0] sa;
    logic [7:0] r;
    logic c, v, ok;
    int s, q, t;
    sa = a; ok = 1'b1; v = 1'b0; c = 1'b0; r = a;
    case (op)
      3'd0: begin r = sa >>> 1; c = a[0]; end
      3'd1: begin r = a >> 1;   c = a[0]; end
      3'd2: begin r = a << 1;   c = a[7]; v = a[7] ^ a[6]; end
      3'd3: begin r = {a[6:0], cin}; c = a[7]; v = a[7] ^ a[6]; end
      3'd4: begin r = {cin, a[7:1]}; c = a[0]; end
      3'd5: begin
        s = sa; q = s / 2; r = q[7:0];
        t = s + ((s < 0) ? 1 : 0); c = t[0];
      end
      default: ok = 1'b0;
    endcase
    return {ok, r, r[7], (r == 8'h00), v, c};
  endfunction

  function automatic string resTag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3, 3'd4: return "R5";
      3'd5: return "R6";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag,
                       input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge
  task automatic step(input logic [2:0] op, input logic [7:0] a,
                      input logic cin, input logic fw);
    logic [12:0] m;
    string ft;
    opcode = op; operand = a; carryIn = cin; flagWrite = fw;
    m = model(op, a, cin);
    #1;
    check(result === m[11:4], resTag(op), result, m[11:4]);
    @(posedge clk);
    if (fw && m[12]) expFlags = m[3:0];
    @(negedge clk);
    if (!m[12])   ft = "R10 flags";
    else if (!fw) ft = "R9 flags";
    else          ft = "R4 R7 R8 flags";
    check({flagN, flagZ, flagV, flagC} === expFlags, ft,
          {4'b0, flagN, flagZ, flagV, flagC}, {4'b0, expFlags});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checkCount++; failCount++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; operand = '0; carryIn = 1'b0; opcode = '0; flagWrite = 1'b0;
    expFlags = 4'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    check({flagN, flagZ, flagV, flagC} === 4'b0, "R11 reset",
          {4'b0, flagN, flagZ, flagV, flagC}, 8'h00);
    rst = 1'b0;

    // directed corners
    step(3'd0, 8'hFF, 1'b0, 1'b1);   // R1 floors -1
    step(3'd0, 8'h81, 1'b0, 1'b1);   // R1, R7
    step(3'd1, 8'h81, 1'b1, 1'b1);   // R2
    step(3'd2, 8'h40, 1'b0, 1'b1);   // R4 sign change
    step(3'd2, 8'hC0, 1'b0, 1'b1);   // R4 no sign change, R3 carry
    step(3'd2, 8'h80, 1'b0, 1'b1);   // R8 zero
    step(3'd3, 8'h81, 1'b1, 1'b1);   // R5 rotate left
    step(3'd4, 8'h01, 1'b1, 1'b1);   // R5 rotate right
    step(3'd5, 8'hFF, 1'b0, 1'b1);   // R6 -1 -> 0
    step(3'd5, 8'hFD, 1'b0, 1'b1);   // R6 -3 -> -1
    step(3'd5, 8'h80, 1'b0, 1'b1);   // R6 -128 -> -64
    step(3'd5, 8'h7F, 1'b0, 1'b1);   // R6 127 -> 63, R7 carry
    step(3'd2, 8'hFF, 1'b0, 1'b1);   // set flags N and C
    step(3'd0, 8'h00, 1'b0, 1'b0);   // R9 hold
    step(3'd6, 8'h00, 1'b1, 1'b1);   // R10 reserved
    step(3'd7, 8'h5A, 1'b0, 1'b1);   // R10 reserved

    // R11 reset beats flagWrite
    opcode = 3'd2; operand = 8'hFF; flagWrite = 1'b1; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    expFlags = 4'b0;
    check({flagN, flagZ, flagV, flagC} === 4'b0, "R11 reset with write",
          {4'b0, flagN, flagZ, flagV, flagC}, 8'h00);
    rst = 1'b0;

    for (int i = 0; i < 400; i++) begin
      step(3'($urandom_range(0, 7)), 8'($urandom), 1'($urandom),
           ($urandom_range(0, 3) != 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule